// File: doc/BRIEF.md
# Configurable Single-Port Block Memory

This block models one memory tile of a programmable-logic fabric as a single-port RAM whose data width, write-collision read behaviour, output-register reset style and active clock edge are all chosen by static configuration inputs. The storage is a fixed array of 512 nine-bit words. Narrow widths view the eight low bits of each word as packed slices. The widest setting pairs two adjacent words into one eighteen-bit location. A ROM setting turns the same array into read-only storage that holds its power-up contents.

The data output comes from a register that loads on the active clock edge. The reset acts only on that register and never on the stored contents. Configuration inputs are expected to change only while reset is held and enable is low. A change of clock polarity at any other time can create a spurious edge.

Top module: `cfg_block_ram`

## Requirements
- R1: `width_sel` selects the port width: 0 gives 1 bit, 1 gives 2 bits, 2 gives 4 bits, 3 gives 9 bits, and 4 to 7 give 18 bits. The used address range is 4096, 2048, 1024, 512 or 256 locations, and higher `addr` bits are ignored. Word i powers up holding (37*i+5) mod 512.
- R2: In the 1, 2 and 4 bit widths, location a sits in word a/(8/W) at bit offset (a mod (8/W))*W, within bits 7:0. A write changes only those W bits. In the 18-bit width, location a is word 2a on `dout[8:0]` and word 2a+1 on `dout[17:9]`.
- R3: With `coll_mode` 0 or 3 (hold mode), a write leaves `dout` unchanged.
- R4: With `coll_mode` 1 (pass-through), a write loads `dout` with `din` masked to the port width.
- R5: With `coll_mode` 2 (old-data), a write loads `dout` with the location's contents from before the write.
- R6: A read (`en`=1, `we`=0) loads `dout` at the active edge with the addressed contents. Output bits above the port width are zero.
- R7: With `en`=0, nothing is written and `dout` holds.
- R8: With `rom_mode`=1, `we` is ignored: the memory is not written, and an enabled cycle behaves as a read.
- R9: With `rst_async`=0, `rst`=1 clears `dout` at the next active edge only.
- R10: With `rst_async`=1, `rst`=1 clears `dout` at once, without a clock edge.
- R11: `clk_inv`=0 makes the rising edge of `clk` active. `clk_inv`=1 makes the falling edge active.
- R12: Reset never alters the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clk_inv | input | 1 | 1 selects the falling edge as the active edge |
| rst | input | 1 | Output register reset, active high |
| rst_async | input | 1 | 1 makes the reset asynchronous |
| rom_mode | input | 1 | 1 disables the write path |
| width_sel | input | 3 | Port width select |
| coll_mode | input | 2 | Output behaviour on a write cycle |
| en | input | 1 | Access enable |
| we | input | 1 | Write enable |
| addr | input | 12 | Location address |
| din | input | 18 | Write data |
| dout | output | 18 | Registered read data |

## Verification
A corrupted slice or a write that spills past its slice does not show on the write cycle. It appears on `dout` one active edge after the first read of the affected word, and that read may use a different width. The reference model therefore keeps a flat bit image and mixes widths between reset phases. A wrong collision choice or a wrong hold shows on the very next active edge. A polarity fault shows half a clock period early or late.

// File: rtl/cfg_block_ram.sv
`timescale 1ns/1ps
module cfg_block_ram #(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        clk_inv,
  input  logic        rst,
  input  logic        rst_async,
  input  logic        rom_mode,
  input  logic [2:0]  width_sel,
  input  logic [1:0]  coll_mode,
  input  logic        en,
  input  logic        we,
  input  logic [11:0] addr,
  input  logic [17:0] din,
  output logic [17:0] dout
);
  localparam int WA = $clog2(DEPTH);
  localparam int AW = WA + 3;

  logic [8:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 9'((i * 37 + 5) % 512);
  end

  wire       aclk = clk ^ clk_inv;
  wire       arst = rst & rst_async;
  wire [2:0] wsel = (width_sel > 3'd4) ? 3'd4 : width_sel;
  wire       wide = (wsel == 3'd4);
  wire       narrow = (wsel < 3'd3);
  wire       wr = en & we & ~rom_mode;

  logic [WA-1:0] w0;
  logic [2:0]    sh;
  logic [7:0]    smask;

  always_comb begin
    w0 = addr[WA-1:0];
    sh = 3'd0;
    smask = 8'hFF;
    case (wsel)
      3'd0: begin w0 = addr[AW-1:3]; sh = addr[2:0];           smask = 8'h01; end
      3'd1: begin w0 = addr[AW-2:2]; sh = {addr[1:0], 1'b0};   smask = 8'h03; end
      3'd2: begin w0 = addr[AW-3:1]; sh = {addr[0], 2'b00};    smask = 8'h0F; end
      3'd3: w0 = addr[WA-1:0];
      default: w0 = {addr[WA-2:0], 1'b0};
    endcase
  end

  wire [WA-1:0] w1 = w0 | WA'(1);
  wire [8:0]    m0 = mem[w0];
  wire [8:0]    m1 = mem[w1];
  wire [7:0]    pmask = smask << sh;
  wire [7:0]    nsel = (m0[7:0] >> sh) & smask;
  wire [7:0]    nput = (din[7:0] & smask) << sh;
  wire [8:0]    n0 = narrow ? {m0[8], (m0[7:0] & ~pmask) | nput} : din[8:0];

  wire [17:0] rdata = narrow ? {10'b0, nsel} : (wide ? {m1, m0} : {9'b0, m0});
  wire [17:0] wview = narrow ? {10'b0, din[7:0] & smask} : (wide ? din : {9'b0, din[8:0]});

  always_ff @(posedge aclk) begin
    if (wr) begin
      mem[w0] <= n0;
      if (wide) mem[w1] <= din[17:9];
    end
  end

  always_ff @(posedge aclk or posedge arst) begin
    if (arst) dout <= '0;
    else if (rst) dout <= '0;
    else if (en) begin
      if (!wr) dout <= rdata;
      else if (coll_mode == 2'd1) dout <= wview;
      else if (coll_mode == 2'd2) dout <= rdata;
    end
  end
endmodule

module cfg_block_ram_chk (
  input logic        clk,
  input logic        clk_inv,
  input logic        rst,
  input logic        rst_async,
  input logic        rom_mode,
  input logic [2:0]  width_sel,
  input logic [1:0]  coll_mode,
  input logic        en,
  input logic        we,
  input logic [17:0] din,
  input logic [17:0] dout
);
  wire aclk = clk ^ clk_inv;

  // R7
  en_low_hold_chk: assert property (@(posedge aclk) disable iff (rst)
    !en |=> $stable(dout));

  // R3
  hold_mode_write_chk: assert property (@(posedge aclk) disable iff (rst)
    (en && we && !rom_mode && (coll_mode == 2'd0 || coll_mode == 2'd3)) |=> $stable(dout));

  // R4
  pass_through_chk: assert property (@(posedge aclk) disable iff (rst)
    (en && we && !rom_mode && coll_mode == 2'd1 && width_sel >= 3'd4) |=> (dout == $past(din)));

  // R6
  one_bit_upper_zero_chk: assert property (@(posedge aclk) disable iff (rst)
    (width_sel == 3'd0) |-> (dout[17:1] == 17'd0));

  // R9
  sync_reset_chk: assert property (@(posedge aclk)
    (rst && !rst_async) |=> (dout == 18'd0));

  // R10
  async_reset_chk: assert property (@(posedge aclk)
    (rst && rst_async) |-> (dout == 18'd0));
endmodule

bind cfg_block_ram cfg_block_ram_chk u_chk (
  .clk(clk), .clk_inv(clk_inv), .rst(rst), .rst_async(rst_async),
  .rom_mode(rom_mode), .width_sel(width_sel), .coll_mode(coll_mode),
  .en(en), .we(we), .din(din), .dout(dout)
);

// File: tb/sim_cfg_block_ram.sv
`timescale 1ns/1ps
module sim_cfg_block_ram;
  logic        clk = 0, clk_inv = 0, rst = 1, rst_async = 0, rom_mode = 0;
  logic [2:0]  width_sel = 3;
  logic [1:0]  coll_mode = 0;
  logic        en = 0, we = 0;
  logic [11:0] addr = 0;
  logic [17:0] din = 0;
  wire  [17:0] dout;

  cfg_block_ram u0 (.*);

  always #4 clk = ~clk;
  wire act = clk ^ clk_inv;

  bit          ref_bits [0:512*9-1];
  logic [17:0] exp_q = 0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  task automatic check(input string tag);
    n_cmp++;
    if (dout !== exp_q) begin
      n_bad++;
      $display("FAIL %s dout=%h expected=%h at %0t", tag, dout, exp_q, $time);
    end
  endtask

  task automatic model(input logic e, input logic w, input logic [11:0] a,
                       input logic [17:0] d, output logic [17:0] res);
    int wd, rng, ai, base, per;
    logic [17:0] rd;
    case (width_sel)
      3'd0: begin wd = 1; rng = 4096; end
      3'd1: begin wd = 2; rng = 2048; end
      3'd2: begin wd = 4; rng = 1024; end
      3'd3: begin wd = 9; rng = 512; end
      default: begin wd = 18; rng = 256; end
    endcase
    ai = int'(a) % rng;
    if (wd < 9) begin
      per = 8 / wd;
      base = (ai / per) * 9 + (ai % per) * wd;
    end else base = ai * wd;
    rd = '0;
    for (int k = 0; k < wd; k++) rd[k] = ref_bits[base + k];
    res = exp_q;
    if (rst) res = '0;
    else if (e) begin
      if (!(w && !rom_mode)) res = rd;
      else begin
        if (coll_mode == 2'd1) begin
          res = '0;
          for (int k = 0; k < wd; k++) res[k] = d[k];
        end else if (coll_mode == 2'd2) res = rd;
        for (int k = 0; k < wd; k++) ref_bits[base + k] = d[k];
      end
    end
  endtask

  task automatic step(input logic e, input logic w, input logic [11:0] a,
                      input logic [17:0] d, input string tag);
    logic [17:0] nx;
    en = e; we = w; addr = a; din = d;
    model(e, w, a, d, nx);
    @(posedge act); #1;
    exp_q = nx;
    check(tag);
  endtask

  task automatic reconfig(input logic [2:0] ws, input logic [1:0] cm,
                          input logic inv, input logic rom);
    en = 0; we = 0; rst = 1; rst_async = 0;
    width_sel = ws; coll_mode = cm; clk_inv = inv; rom_mode = rom;
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    rst = 0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++)
      for (int b = 0; b < 9; b++) ref_bits[i*9 + b] = bit'(((i * 37 + 5) % 512) >> b);

    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    rst = 0;

    for (int i = 0; i < 6; i++) step(1, 0, 12'(i), 0, "R1");
    reconfig(3'd4, 2'd0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 12'(i + 100), 0, "R1");
    reconfig(3'd2, 2'd0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 12'(i + 4090), 0, "R1");

    reconfig(3'd0, 2'd0, 0, 0);
    for (int i = 8; i < 16; i++) step(1, 1, 12'(i), 18'(i & 1), "R2");
    reconfig(3'd3, 2'd0, 0, 0);
    step(1, 0, 12'd1, 0, "R2");
    reconfig(3'd1, 2'd2, 0, 0);
    step(1, 1, 12'd9, 18'h3FFFF, "R2");
    reconfig(3'd3, 2'd0, 0, 0);
    step(1, 0, 12'd2, 0, "R2");

    reconfig(3'd3, 2'd0, 1, 0);
    begin
      logic [17:0] nx;
      en = 1; we = 0; addr = 12'd3; din = 0;
      model(1, 0, 12'd3, 0, nx);
      @(posedge clk); #1;
      check("R11");
      @(negedge clk); #1;
      exp_q = nx;
      check("R11");
    end

    for (int ws = 0; ws < 5; ws++)
      for (int cm = 0; cm < 4; cm++) begin
        reconfig(3'(ws), 2'(cm), 1'((ws + cm) % 2), 0);
        for (int n = 0; n < 40; n++) begin
          logic e, w;
          string tag;
          e = ($urandom % 8) != 0;
          w = $urandom % 2;
          if (!e) tag = "R7";
          else if (!w) tag = "R6";
          else if (cm == 1) tag = "R4";
          else if (cm == 2) tag = "R5";
          else tag = "R3";
          step(e, w, 12'($urandom), 18'($urandom), tag);
        end
      end

    reconfig(3'd3, 2'd1, 0, 1);
    for (int i = 0; i < 6; i++) step(1, 1, 12'(i * 7), 18'h155, "R8");
    for (int i = 0; i < 6; i++) step(1, 0, 12'(i * 7), 0, "R8");

    reconfig(3'd4, 2'd0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 12'(i * 31), 0, "R12");

    step(1, 0, 12'd5, 0, "R6");
    #2; rst = 1; rst_async = 0; #1;
    check("R9");
    step(1, 0, 12'd6, 0, "R9");
    rst = 0;
    step(1, 0, 12'd7, 0, "R6");
    #2; rst_async = 1; rst = 1; #1;
    exp_q = 0;
    check("R10");
    step(0, 0, 0, 0, "R10");
    rst = 0; rst_async = 0;
    step(1, 0, 12'd7, 0, "R12");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule